// File: doc/BRIEF.md
# TDM Frame Transmitter

This block turns a stream of audio words into time-division multiplexed frames on one serial data line. A frame holds a programmable number of slots (1 to 32), and every slot lasts a programmable number of bit clocks (1 to 32). A word is sent most significant bit first. It may be shorter than its slot, and the bit clocks after the word carry zeros. A 32-bit slot mask selects which slots carry data. A masked slot keeps its place in the frame, sends zeros and takes no word from the queue.

Words enter through a parallel write port into an internal queue. The queue reports full, not full, empty and at-or-below-half occupancy. Its sticky error flags record a write that was refused and a data slot that began with nothing queued. In master mode the block divides its system clock down to a bit clock and drives both the bit clock and the frame marker. In slave mode it takes both from outside and locks to them. The frame marker is either one bit clock wide or one slot wide.

Top module: `tdm_tx`

## Requirements
- R1: Out of reset the queue is empty: `empty`=1, `half_empty`=1, `not_full`=1, `full`=0. `half_empty` is 1 while occupancy <= DEPTH/2. `full` is 1 at DEPTH words, and `not_full` is its inverse.
- R2: A write while `full` stores nothing and sets `overflow`. `overflow` stays set until `clear`.
- R3: A `clear` pulse empties the queue and resets `overflow` and `underflow`. A write in the same cycle is dropped.
- R4: In master mode each `sck_out` phase lasts `clk_div`+1 system clocks. `sck_out` is low while `tx_en` is 0 or in slave mode.
- R5: A frame has `num_ch_m1`+1 slots of `ch_len_m1`+1 bits. A data slot sends the low `word_len_m1`+1 bits of its word, most significant first, then zeros to the end of the slot. Output bits change on the falling edge of the bit clock.
- R6: A slot whose bit in `ch_mask` (bit i = slot i) is 0 sends zeros and takes no word from the queue.
- R7: With `ws_full`=0 the frame marker is high only for the bit period just before slot 0 bit 0, which is the last bit of the frame.
- R8: With `ws_full`=1 the frame marker is high for that same bit period and for the first `ch_len_m1` bits of slot 0.
- R9: When a data slot starts with the queue empty, the slot is sent as zeros and `underflow` is set (sticky). The frame position keeps advancing.
- R10: With `tx_en` at 0, `sdo` and `ws_out` are 0 in the same cycle and `sck_out` is 0 one clock later. Re-enabling starts again from the marker bit that precedes a frame.
- R11: In slave mode `sck_out` and `ws_out` stay 0. Bits advance on falling `sck_in` edges. `ws_in` is sampled on rising `sck_in` edges. The falling edge that follows the first sample where `ws_in` went from 0 to high starts slot 0. Before that point `sdo` is 0.
- R12: In master mode the first bit period after enable is the frame marker bit, with `sdo`=0, and slot 0 follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Run enable; low stops output and rewinds the frame |
| clear | input | 1 | Empties the queue and clears sticky flags |
| is_slave | input | 1 | 1: follow sck_in/ws_in; 0: generate timing |
| ws_full | input | 1 | 0: marker one bit wide; 1: marker one slot wide |
| clk_div | input | DIV_W | Master bit-clock phase length minus one, in system clocks |
| num_ch_m1 | input | 5 | Slots per frame minus one |
| ch_len_m1 | input | 5 | Bits per slot minus one |
| word_len_m1 | input | 5 | Bits per word minus one (<= ch_len_m1) |
| ch_mask | input | 32 | Slot enable, bit i for slot i |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Word to queue, right-justified |
| full | output | 1 | Queue holds DEPTH words |
| not_full | output | 1 | Queue can accept a word |
| half_empty | output | 1 | Occupancy <= DEPTH/2; also used as a trigger |
| empty | output | 1 | Queue holds no word |
| overflow | output | 1 | Sticky: write refused while full |
| underflow | output | 1 | Sticky: data slot began with empty queue |
| sck_in | input | 1 | Bit clock in slave mode |
| ws_in | input | 1 | Frame marker in slave mode |
| sck_out | output | 1 | Bit clock in master mode |
| ws_out | output | 1 | Frame marker in master mode |
| sdo | output | 1 | Serial data |

## Verification
A wrong slot or bit counter appears on the ports within one frame. The frame marker then falls on a bit period other than the one the stream model predicts, and every later word lands in the wrong place. A wrong queue pointer or a mask decode that takes or skips a word shows up at the first data slot after it. The word in that slot and in every later slot differs from the model, and the final empty or underflow flag no longer matches. Queue count faults show up on the level flags as soon as the occupancy crosses DEPTH/2 or reaches DEPTH.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 5;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [WORD_W-1:0] word_t;

  // Serial bit at offset b of a slot: word left-justified, MSB first, zero tail.
  function automatic logic slot_bit(word_t w, idx_t wlm1, idx_t b);
    word_t j;
    j = w << (idx_t'(WORD_W - 1) - wlm1);
    return (b <= wlm1) ? j[idx_t'(WORD_W - 1) - b] : 1'b0;
  endfunction

  // Frame marker level for the bit at (slot, b).
  function automatic logic marker_on(idx_t slot, idx_t b, idx_t nm1, idx_t lm1, logic wide);
    logic last_bit, lead;
    last_bit = (slot == nm1) && (b == lm1);
    lead     = wide && (slot == '0) && (b < lm1);
    return last_bit || lead;
  endfunction
endpackage

// File: rtl/tdm_tx_fifo.sv
module tdm_tx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push_req,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty,
  output logic         half_empty,
  output logic         overflow
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full       = (cnt == DEPTH_C);
  assign empty      = (cnt == '0);
  assign half_empty = (cnt <= HALF_C);
  assign do_push    = push_req && !full && !clear;
  assign do_pop     = pop && !empty && !clear;
  assign rd_data    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; overflow <= 1'b0;
    end else if (clear) begin
      wp <= '0; rp <= '0; cnt <= '0; overflow <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST_P) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push_req && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_tx_clkgen.sv
module tdm_tx_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             is_slave,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             sck_in,
  input  logic             ws_in,
  output logic             sck_out,
  output logic             fall_ev,
  output logic             frame_sync
);
  logic [DIV_W-1:0] cnt;
  logic             sck_q, sck_d, ws_last, sync_pend;
  logic             s_rise, s_fall, m_fall, m_run, s_run;

  assign m_run  = tx_en && !is_slave;
  assign s_run  = tx_en && is_slave;
  assign s_rise = sck_in && !sck_d;
  assign s_fall = !sck_in && sck_d;
  assign m_fall = sck_q && (cnt == clk_div);

  assign fall_ev    = m_run ? m_fall : (s_run && s_fall);
  assign frame_sync = s_run && s_fall && sync_pend;
  assign sck_out    = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sck_q <= 1'b0; sck_d <= 1'b0;
    end else begin
      sck_d <= sck_in;
      if (!m_run) begin
        cnt <= '0; sck_q <= 1'b0;
      end else if (cnt == clk_div) begin
        cnt <= '0; sck_q <= !sck_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_last <= 1'b0; sync_pend <= 1'b0;
    end else if (!s_run) begin
      ws_last <= 1'b0; sync_pend <= 1'b0;
    end else if (s_rise) begin
      ws_last <= ws_in;
      if (ws_in && !ws_last) sync_pend <= 1'b1;
    end else if (s_fall) begin
      sync_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdm_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_en,
  input  logic  is_slave,
  input  logic  ws_full,
  input  idx_t  num_ch_m1,
  input  idx_t  ch_len_m1,
  input  idx_t  word_len_m1,
  input  word_t ch_mask,
  input  logic  fall_ev,
  input  logic  frame_sync,
  input  logic  fifo_empty,
  input  word_t fifo_data,
  output logic  pop,
  output logic  uflow_ev,
  output logic  ws_out,
  output logic  sdo
);
  idx_t  slot_q, bit_q, nxt_slot, nxt_bit;
  word_t cur_word;
  logic  locked, advance, load, slot_on;

  assign advance = fall_ev && (!is_slave || locked || frame_sync);

  always_comb begin
    if (frame_sync) begin
      nxt_slot = '0; nxt_bit = '0;
    end else if (bit_q == ch_len_m1) begin
      nxt_bit  = '0;
      nxt_slot = (slot_q == num_ch_m1) ? '0 : slot_q + 1'b1;
    end else begin
      nxt_bit  = bit_q + 1'b1;
      nxt_slot = slot_q;
    end
  end

  assign load     = advance && (nxt_bit == '0);
  assign slot_on  = ch_mask[nxt_slot];
  assign pop      = load && slot_on && !fifo_empty;
  assign uflow_ev = load && slot_on && fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0; bit_q <= '0; cur_word <= '0; locked <= 1'b0;
    end else if (!tx_en) begin
      slot_q <= num_ch_m1; bit_q <= ch_len_m1; cur_word <= '0; locked <= 1'b0;
    end else if (advance) begin
      slot_q <= nxt_slot;
      bit_q  <= nxt_bit;
      if (frame_sync) locked <= 1'b1;
      if (load) cur_word <= pop ? fifo_data : '0;
    end
  end

  assign ws_out = tx_en && !is_slave && marker_on(slot_q, bit_q, num_ch_m1, ch_len_m1, ws_full);
  assign sdo    = tx_en && (!is_slave || locked) && slot_bit(cur_word, word_len_m1, bit_q);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             clear,
  input  logic             is_slave,
  input  logic             ws_full,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [4:0]       num_ch_m1,
  input  logic [4:0]       ch_len_m1,
  input  logic [4:0]       word_len_m1,
  input  logic [31:0]      ch_mask,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic             full,
  output logic             not_full,
  output logic             half_empty,
  output logic             empty,
  output logic             overflow,
  output logic             underflow,
  input  logic             sck_in,
  input  logic             ws_in,
  output logic             sck_out,
  output logic             ws_out,
  output logic             sdo
);
  logic  fall_ev, frame_sync, pop, uflow_ev;
  word_t fifo_data;

  tdm_tx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(clear), .push_req(wr_en), .wr_data(wr_data),
    .pop(pop), .rd_data(fifo_data), .full(full), .empty(empty),
    .half_empty(half_empty), .overflow(overflow)
  );

  tdm_tx_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .is_slave(is_slave), .clk_div(clk_div),
    .sck_in(sck_in), .ws_in(ws_in), .sck_out(sck_out), .fall_ev(fall_ev),
    .frame_sync(frame_sync)
  );

  tdm_tx_framer u_frm (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .is_slave(is_slave), .ws_full(ws_full),
    .num_ch_m1(num_ch_m1), .ch_len_m1(ch_len_m1), .word_len_m1(word_len_m1),
    .ch_mask(ch_mask), .fall_ev(fall_ev), .frame_sync(frame_sync),
    .fifo_empty(empty), .fifo_data(fifo_data), .pop(pop), .uflow_ev(uflow_ev),
    .ws_out(ws_out), .sdo(sdo)
  );

  assign not_full = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        underflow <= 1'b0;
    else if (clear)    underflow <= 1'b0;
    else if (uflow_ev) underflow <= 1'b1;
  end
endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic clear,
  input logic wr_en,
  input logic is_slave,
  input logic full,
  input logic empty,
  input logic half_empty,
  input logic overflow,
  input logic underflow,
  input logic sck_out,
  input logic ws_out,
  input logic sdo,
  input logic fall_ev,
  input logic uflow_ev
);
  assert_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (half_empty && !full));

  assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !clear) |=> overflow);

  assert_ovf_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (empty && !overflow && !underflow));

  assert_sck_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && !is_slave) |=> !sck_out);

  assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !fall_ev) |=> (!tx_en || $stable(sdo)));

  assert_uflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_ev |-> empty);

  assert_uflow_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_ev && !clear) |=> underflow);

  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !sck_out);

  assert_slave_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_slave |-> (!sck_out && !ws_out));
endmodule

bind tdm_tx tdm_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .clear(clear), .wr_en(wr_en),
  .is_slave(is_slave), .full(full), .empty(empty), .half_empty(half_empty),
  .overflow(overflow), .underflow(underflow), .sck_out(sck_out), .ws_out(ws_out),
  .sdo(sdo), .fall_ev(fall_ev), .uflow_ev(uflow_ev)
);

// File: tb/tdm_tx_test.sv
module tdm_tx_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, clear = 0, is_slave = 0, ws_full = 0, wr_en = 0;
  logic [7:0]  clk_div = 0;
  logic [4:0]  num_ch_m1 = 0, ch_len_m1 = 0, word_len_m1 = 0;
  logic [31:0] ch_mask = 0, wr_data = 0;
  logic sck_in = 0, ws_in = 0;
  logic full, not_full, half_empty, empty, overflow, underflow, sck_out, ws_out, sdo;

  int checks = 0, failures = 0;
  logic [31:0] q [$];

  always #10 clk = !clk;

  tdm_tx #(.DEPTH(DEPTH), .DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .clear(clear), .is_slave(is_slave),
    .ws_full(ws_full), .clk_div(clk_div), .num_ch_m1(num_ch_m1), .ch_len_m1(ch_len_m1),
    .word_len_m1(word_len_m1), .ch_mask(ch_mask), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .not_full(not_full), .half_empty(half_empty), .empty(empty),
    .overflow(overflow), .underflow(underflow), .sck_in(sck_in), .ws_in(ws_in),
    .sck_out(sck_out), .ws_out(ws_out), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_clear();
    clear = 1;
    @(negedge clk);
    clear = 0;
    q.delete();
  endtask

  // expected serial bit: low wl bits of w, MSB first, then zeros
  function automatic logic exp_bit(logic [31:0] w, int wl, int b);
    if (b >= wl) return 1'b0;
    return w[wl - 1 - b];
  endfunction

  function automatic logic exp_ws(int p, int total, int len, logic wide);
    return (p == total - 1) || (wide && p < len - 1);
  endfunction

  // Waits for a rising sck_out seen at a falling clk edge; returns clocks waited.
  task automatic wait_rise(output int cyc);
    logic pv;
    pv = sck_out; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (sck_out && !pv) break;
      pv = sck_out;
    end
  endtask

  task automatic run_master(input int nch, input int len, input int wl, input logic [31:0] mask,
                            input logic wide, input int div);
    int total, en_cnt, nw, qi, cyc;
    logic [31:0] cur;
    logic uf;
    do_clear();
    is_slave = 0; ws_full = wide; clk_div = 8'(div);
    num_ch_m1 = 5'(nch - 1); ch_len_m1 = 5'(len - 1); word_len_m1 = 5'(wl - 1); ch_mask = mask;
    total = nch * len;
    en_cnt = 0;
    for (int s = 0; s < nch; s++) if (mask[s]) en_cnt++;
    nw = (2 * en_cnt > DEPTH) ? DEPTH : 2 * en_cnt;
    for (int i = 0; i < nw; i++) begin
      q.push_back($urandom);
      put(q[i]);
    end
    @(negedge clk);
    tx_en = 1;
    // marker bit before the first frame
    wait_rise(cyc);
    chk(cyc == div + 1, "R4 first phase", 32'(cyc), 32'(div + 1));
    chk(ws_out == 1'b1 && sdo == 1'b0, "R12 lead bit", {30'd0, ws_out, sdo}, 32'h2);
    qi = 0; uf = 0; cur = 0;
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < nch; s++)
        for (int b = 0; b < len; b++) begin
          if (b == 0) begin
            if (mask[s]) begin
              if (qi < nw) begin cur = q[qi]; qi++; end
              else begin cur = 0; uf = 1; end
            end else cur = 0;
          end
          wait_rise(cyc);
          if (f == 0 && s == 0 && b == 0)
            chk(cyc == 2 * (div + 1), "R4 period", 32'(cyc), 32'(2 * (div + 1)));
          chk(sdo == exp_bit(cur, wl, b), mask[s] ? "R5 data bit" : "R6 masked slot",
              {31'd0, sdo}, {31'd0, exp_bit(cur, wl, b)});
          chk(ws_out == exp_ws(s * len + b, total, len, wide), wide ? "R8 marker" : "R7 marker",
              {31'd0, ws_out}, {31'd0, exp_ws(s * len + b, total, len, wide)});
        end
    tx_en = 0;
    #1;
    chk(sdo == 0 && ws_out == 0, "R10 stop", {30'd0, ws_out, sdo}, 0);
    @(negedge clk);
    chk(sck_out == 0, "R10 sck idle", {31'd0, sck_out}, 0);
    chk(underflow == uf, "R9 underflow flag", {31'd0, underflow}, {31'd0, uf});
    chk(empty == 1'b1, "R6 words consumed", {31'd0, empty}, 1);
  endtask

  task automatic slave_bit(input logic w, output logic d);
    sck_in = 0; ws_in = w;
    repeat (3) @(negedge clk);
    sck_in = 1;
    repeat (3) @(negedge clk);
    d = sdo;
  endtask

  task automatic run_slave(input int nch, input int len, input int wl, input logic [31:0] mask,
                           input logic wide);
    int total, en_cnt, nw, qi;
    logic [31:0] cur;
    logic d;
    do_clear();
    is_slave = 1; ws_full = wide;
    num_ch_m1 = 5'(nch - 1); ch_len_m1 = 5'(len - 1); word_len_m1 = 5'(wl - 1); ch_mask = mask;
    total = nch * len;
    en_cnt = 0;
    for (int s = 0; s < nch; s++) if (mask[s]) en_cnt++;
    nw = (2 * en_cnt > DEPTH) ? DEPTH : 2 * en_cnt;
    for (int i = 0; i < nw; i++) begin
      q.push_back($urandom);
      put(q[i]);
    end
    tx_en = 1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      slave_bit(1'b0, d);
      chk(d == 0, "R11 before lock", {31'd0, d}, 0);
    end
    slave_bit(1'b1, d);
    chk(d == 0, "R11 marker bit", {31'd0, d}, 0);
    qi = 0; cur = 0;
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < nch; s++)
        for (int b = 0; b < len; b++) begin
          if (b == 0) begin
            if (mask[s] && qi < nw) begin cur = q[qi]; qi++; end
            else cur = 0;
          end
          slave_bit(exp_ws(s * len + b, total, len, wide), d);
          chk(d == exp_bit(cur, wl, b), "R11 slave data", {31'd0, d}, {31'd0, exp_bit(cur, wl, b)});
          chk(sck_out == 0 && ws_out == 0, "R11 outputs quiet", {30'd0, sck_out, ws_out}, 0);
        end
    tx_en = 0; is_slave = 0; sck_in = 0; ws_in = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(empty && half_empty && not_full && !full, "R1 reset flags",
        {28'd0, empty, half_empty, not_full, full}, 32'hE);
    chk(!overflow && !underflow && !sdo && !sck_out && !ws_out, "R1 reset outputs",
        {27'd0, overflow, underflow, sdo, sck_out, ws_out}, 0);
    for (int i = 0; i < DEPTH / 2; i++) put($urandom);
    chk(half_empty == 1, "R1 half at depth/2", {31'd0, half_empty}, 1);
    put($urandom);
    chk(half_empty == 0, "R1 above half", {31'd0, half_empty}, 0);
    for (int i = DEPTH / 2 + 1; i < DEPTH; i++) put($urandom);
    chk(full && !not_full && !overflow, "R1 full", {29'd0, full, not_full, overflow}, 32'h4);
    put(32'hDEAD);
    chk(overflow == 1 && full == 1, "R2 overflow", {30'd0, overflow, full}, 3);
    repeat (4) @(negedge clk);
    chk(overflow == 1, "R2 sticky", {31'd0, overflow}, 1);
    clear = 1; wr_en = 1; wr_data = 32'h5;
    @(negedge clk);
    clear = 0; wr_en = 0;
    chk(empty && !overflow && !underflow, "R3 clear", {29'd0, empty, overflow, underflow}, 32'h4);

    // directed corners
    run_master(2, 8, 8, 32'h3, 1'b0, 0);
    run_master(1, 32, 32, 32'h1, 1'b1, 1);
    run_master(32, 2, 1, 32'h5555_5555, 1'b0, 0);
    run_master(4, 6, 3, 32'h5, 1'b1, 2);
    // constrained random
    for (int r = 0; r < 6; r++) begin
      int nch, len, wl;
      nch = 1 + int'($urandom % 8);
      len = 4 + int'($urandom % 14);
      wl  = 1 + int'($urandom % len);
      run_master(nch, len, wl, $urandom | 32'h1, 1'($urandom), int'($urandom % 3));
    end
    run_slave(3, 5, 4, 32'h5, 1'b0);
    run_slave(2, 6, 6, 32'h3, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule